// File: doc/BRIEF.md
# Three-Stage Load/Store Pipelined Core

A small in-order processor core with a three-stage pipeline: fetch, execute and store/writeback. Instructions are 16 bits wide and fixed in format, so decoding happens inside the execute stage and there is no separate decode stage. Six general registers, coded 0 to 5 and called A to F, supply every arithmetic operand. Data memory is reached only through LOAD and STORE. The register-to-register operations are add, subtract and multiply. An immediate load and two branch forms complete the set. A branch is delayed: the instruction right after it always executes.

The core drives two synchronous memories, one for instructions and one for data. Each memory answers an access in exactly one clock cycle. Because that latency is fixed, the memory ports carry no valid/ready handshake and there is no back-pressure. The data memory must return read data on the edge that follows the request, and the core cannot be throttled.

The core has no operand forwarding. An instruction that reads a register written by the instruction directly ahead of it is held for one cycle, and a bubble goes down the pipe. A HALT instruction freezes fetch and lets older instructions drain. It then raises `done`, which stays high until reset.

Top module: `pl3_core`

## Requirements
- R1: While reset is low, and on the first cycle after it, `imem_addr` is 0, `dmem_en` is low and `done` is low. All six registers start at zero.
- R2: Instruction word layout: bits [15:12] hold the opcode, [11:9] the destination/first register `rd`, [8:6] the second register `rs`, and [5:0] a zero-extended immediate or address. Opcodes: 0 NOP, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 PROD, 6 LDI, 7 BRA, 8 BRZ, 9 HALT. Opcodes 10 to 15 act as NOP.
- R3: In its execute cycle, STORE asserts `dmem_en` and `dmem_we`, with `dmem_addr` = imm and `dmem_wdata` = register `rd`. LOAD asserts `dmem_en` with `dmem_we` low and writes the `dmem_rdata` returned on the next cycle into `rd`. `dmem_we` is never high without `dmem_en`.
- R4: ADD, SUB and PROD set `rd` to `rd`+`rs`, `rd`−`rs` and `rd`×`rs`, each reduced modulo 2^DW. LDI sets `rd` to the zero-extended immediate.
- R5: An instruction that reads a register written by the instruction directly ahead of it is held for exactly one cycle, and `imem_addr` holds during that cycle. A dependency two or more instructions apart causes no hold.
- R6: BRA is delayed by one slot. The instruction after BRA executes, and then execution continues at the immediate address. On the cycle after BRA executes, `imem_addr` equals its target.
- R7: BRZ branches, with the same single delay slot, only when register `rd` is zero. Otherwise execution falls through.
- R8: An instruction that uses a register field containing code 6 or 7 behaves as NOP. It makes no memory access, writes no register and causes no hold.
- R9: Instructions after HALT do not execute. Two cycles after HALT executes, `done` rises and stays high. From then on `imem_addr` is frozen and `dmem_en` stays low.
- R10: With no holds, a program that executes N instructions ending in HALT raises `done` on the (N+2)th rising edge after reset is released. Each hold adds one edge.
- R11: A register keeps its value after being read as an operand, until a later write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 6 | Instruction fetch address |
| imem_rdata | input | 16 | Instruction word, one cycle after its address |
| dmem_en | output | 1 | Data memory access this cycle |
| dmem_we | output | 1 | Access is a write |
| dmem_addr | output | 6 | Data memory address |
| dmem_wdata | output | DW (16) | Data memory write data |
| dmem_rdata | input | DW (16) | Data memory read data, one cycle after a read |
| done | output | 1 | Core has halted and drained |

## Verification
Each test program is interpreted by an instruction-level model in the bench. The model predicts the data-memory writes in order, the final memory image and the number of holds, and from those the edge on which `done` rises. The multiply sequence (two loads, a product, a store) contains two back-to-back dependencies and so separates a missing or doubled hold from a correct single one. A chain of independent immediate loads with operands two apart shows that no needless bubble is added. Branch programs with the skipped instructions placed between the slot and the target separate a correct delay slot from a squashed or an extra one, and a zero test on a non-zero register separates a taken BRZ from a not-taken one. Programs with illegal register codes, or with stores placed after HALT, show at the memory port that nothing leaks out.

// File: rtl/pl3_pkg.sv
package pl3_pkg;
  localparam int IW   = 16;
  localparam int OPW  = 4;
  localparam int RW   = 3;
  localparam int IMMW = 6;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_PROD  = 4'd5,
    OP_LDI   = 4'd6,
    OP_BRA   = 4'd7,
    OP_BRZ   = 4'd8,
    OP_HALT  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_MUL,
    ALU_IMM
  } alu_e;

  // decoded control for one instruction in execute
  typedef struct packed {
    logic             use_a;   // reads rd field
    logic             use_b;   // reads rs field
    logic             wr;      // writes rd in store stage
    logic             load;
    logic             store;
    logic             jmp;
    logic             jz;
    logic             halt;
    alu_e             alu;
    logic [RW-1:0]    rd;
    logic [RW-1:0]    rs;
    logic [IMMW-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/pl3_decode.sv
module pl3_decode
  import pl3_pkg::*;
#(
  parameter int NREG = 6
) (
  input  logic [IW-1:0] ir,
  output dec_t          dec
);
  localparam logic [RW-1:0] LAST = RW'(NREG - 1);

  logic [OPW-1:0] opc;
  dec_t           raw;
  logic           bad;

  always_comb begin
    opc     = ir[IW-1 -: OPW];
    raw     = '0;
    raw.alu = ALU_ADD;
    raw.rd  = ir[IW-OPW-1 -: RW];
    raw.rs  = ir[IW-OPW-RW-1 -: RW];
    raw.imm = ir[IMMW-1:0];
    case (opc)
      OP_LOAD:  begin raw.wr = 1'b1; raw.load = 1'b1; end
      OP_STORE: begin raw.use_a = 1'b1; raw.store = 1'b1; end
      OP_ADD:   begin raw.use_a = 1'b1; raw.use_b = 1'b1; raw.wr = 1'b1; raw.alu = ALU_ADD; end
      OP_SUB:   begin raw.use_a = 1'b1; raw.use_b = 1'b1; raw.wr = 1'b1; raw.alu = ALU_SUB; end
      OP_PROD:  begin raw.use_a = 1'b1; raw.use_b = 1'b1; raw.wr = 1'b1; raw.alu = ALU_MUL; end
      OP_LDI:   begin raw.wr = 1'b1; raw.alu = ALU_IMM; end
      OP_BRA:   raw.jmp = 1'b1;
      OP_BRZ:   begin raw.use_a = 1'b1; raw.jz = 1'b1; end
      OP_HALT:  raw.halt = 1'b1;
      default:  ;
    endcase
    // a used register field outside the file turns the word into a NOP
    bad = ((raw.use_a || raw.wr) && (raw.rd > LAST)) ||
          (raw.use_b && (raw.rs > LAST));
    dec = bad ? dec_t'('0) : raw;
  end
endmodule

// File: rtl/pl3_regfile.sv
module pl3_regfile
  import pl3_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [RW-1:0] ra0,
  input  logic [RW-1:0] ra1,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1
);
  logic [DW-1:0] qv [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n) r <= '0;
      else if (we && (wa == RW'(g))) r <= wd;
    end
    assign qv[g] = r;
  end

  always_comb begin
    rd0 = '0;
    rd1 = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ra0 == RW'(i)) rd0 = qv[i];
      if (ra1 == RW'(i)) rd1 = qv[i];
    end
  end
endmodule

// File: rtl/pl3_alu.sv
module pl3_alu
  import pl3_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_e            sel,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [IMMW-1:0] imm,
  output logic [DW-1:0]   y
);
  always_comb begin
    case (sel)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_MUL: y = a * b;
      default: y = DW'(imm);
    endcase
  end
endmodule

// File: rtl/pl3_core.sv
module pl3_core
  import pl3_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [IMMW-1:0] imem_addr,
  input  logic [IW-1:0]   imem_rdata,
  output logic            dmem_en,
  output logic            dmem_we,
  output logic [IMMW-1:0] dmem_addr,
  output logic [DW-1:0]   dmem_wdata,
  input  logic [DW-1:0]   dmem_rdata,
  output logic            done
);
  // fetch / execute state
  logic [IMMW-1:0] pc;
  logic            ex_vld;
  logic            replay;
  logic [IW-1:0]   held_ir;
  logic            halted;
  logic [IW-1:0]   cur_ir;
  dec_t            dec;
  logic [DW-1:0]   rdv_a, rdv_b, alu_y;
  logic            haz_a, haz_b, stall, ex_go, take, halt_now;

  // store stage state
  logic            os_vld, os_wr, os_load, os_halt;
  logic [RW-1:0]   os_rd;
  logic [DW-1:0]   os_res;
  logic            wb_we;
  logic [DW-1:0]   wb_data;

  // a held instruction is replayed from the hold register, the memory
  // word that arrives in that cycle is fetched again afterwards
  assign cur_ir = replay ? held_ir : imem_rdata;

  pl3_decode #(.NREG(NREG)) u_dec (
    .ir  (cur_ir),
    .dec (dec)
  );

  pl3_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_we),
    .wa    (os_rd),
    .wd    (wb_data),
    .ra0   (dec.rd),
    .ra1   (dec.rs),
    .rd0   (rdv_a),
    .rd1   (rdv_b)
  );

  pl3_alu #(.DW(DW)) u_alu (
    .sel (dec.alu),
    .a   (rdv_a),
    .b   (rdv_b),
    .imm (dec.imm),
    .y   (alu_y)
  );

  // read-after-write against the instruction one stage ahead
  assign haz_a    = dec.use_a && os_vld && os_wr && (os_rd == dec.rd);
  assign haz_b    = dec.use_b && os_vld && os_wr && (os_rd == dec.rs);
  assign stall    = ex_vld && (haz_a || haz_b);
  assign ex_go    = ex_vld && !stall;
  assign take     = ex_go && (dec.jmp || (dec.jz && (rdv_a == '0)));
  assign halt_now = ex_go && dec.halt;

  assign imem_addr  = pc;
  assign dmem_en    = ex_go && (dec.load || dec.store);
  assign dmem_we    = ex_go && dec.store;
  assign dmem_addr  = dec.imm;
  assign dmem_wdata = rdv_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      ex_vld  <= 1'b0;
      replay  <= 1'b0;
      held_ir <= '0;
      halted  <= 1'b0;
    end else begin
      replay <= stall;
      if (stall) held_ir <= cur_ir;
      if (halt_now) halted <= 1'b1;
      if (stall || halt_now || halted) pc <= pc;
      else if (take) pc <= dec.imm;
      else pc <= pc + IMMW'(1);
      if (!stall) ex_vld <= !(halt_now || halted);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      os_vld  <= 1'b0;
      os_wr   <= 1'b0;
      os_load <= 1'b0;
      os_halt <= 1'b0;
      os_rd   <= '0;
      os_res  <= '0;
      done    <= 1'b0;
    end else begin
      os_vld  <= ex_go;
      os_wr   <= dec.wr;
      os_load <= dec.load;
      os_halt <= dec.halt;
      os_rd   <= dec.rd;
      os_res  <= alu_y;
      if (os_vld && os_halt) done <= 1'b1;
    end
  end

  assign wb_we   = os_vld && os_wr;
  assign wb_data = os_load ? dmem_rdata : os_res;
endmodule

// File: rtl/pl3_core_chk.sv
module pl3_core_chk
  import pl3_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [IMMW-1:0] imem_addr,
  input logic            dmem_en,
  input logic            dmem_we,
  input logic            done,
  input logic            stall,
  input logic            ex_vld,
  input logic [IW-1:0]   cur_ir
);
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> dmem_en); // R3

  AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R5

  AST_HOLD_FREEZES_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(imem_addr)); // R5

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld && !stall && (cur_ir[15:12] == 4'd7)) |=> (imem_addr == $past(cur_ir[5:0]))); // R6

  AST_BAD_REG_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld && (cur_ir[11:10] == 2'b11)) |-> !dmem_en); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R9

  AST_DONE_FETCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(imem_addr)); // R9

  AST_DONE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dmem_en); // R9
endmodule

bind pl3_core pl3_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .dmem_en   (dmem_en),
  .dmem_we   (dmem_we),
  .done      (done),
  .stall     (stall),
  .ex_vld    (ex_vld),
  .cur_ir    (cur_ir)
);

// File: tb/pl3_core_test.sv
`timescale 1ns/1ps
module pl3_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic        dmem_en, dmem_we;
  logic [5:0]  dmem_addr;
  logic [15:0] dmem_wdata;
  logic [15:0] dmem_rdata;
  logic        done;

  always #10 clk = ~clk;  // 50 MHz

  pl3_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_en    (dmem_en),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .done       (done)
  );

  logic [15:0] imem [64];
  logic [15:0] dmem [64];
  logic [15:0] ref_mem [64];
  logic [15:0] prog [64];
  int          plen;

  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr];
    if (dmem_en) begin
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
      else dmem_rdata <= dmem[dmem_addr];
    end
  end

  int    nchk = 0;
  int    nfail = 0;
  string cur_tag = "";

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", cur_tag, what, act, exp);
    end
  endtask

  // scoreboard of expected data-memory writes
  logic [5:0]  qa [$];
  logic [15:0] qd [$];

  always @(negedge clk) begin
    if (rst_n && dmem_en && dmem_we) begin
      if (qa.size() == 0) begin
        chk(1'b0, "R3 unexpected store addr", int'(dmem_addr), -1);
      end else begin
        logic [5:0]  ea;
        logic [15:0] ed;
        ea = qa.pop_front();
        ed = qd.pop_front();
        chk(dmem_addr == ea, "R3 store address", int'(dmem_addr), int'(ea));
        chk(dmem_wdata == ed, "store data", int'(dmem_wdata), int'(ed));
      end
    end
  end

  task automatic new_prog();
    plen = 0;
    for (int i = 0; i < 64; i++) prog[i] = 16'h0;
  endtask

  task automatic emit(input int op, input int rd, input int rs, input int imm);
    prog[plen] = {4'(op), 3'(rd), 3'(rs), 6'(imm)};
    plen++;
  endtask

  task automatic poke(input int a, input int v);
    dmem[a]    = 16'(v);
    ref_mem[a] = 16'(v);
  endtask

  task automatic load_mems();
    for (int i = 0; i < 64; i++) begin
      imem[i]    = prog[i];
      dmem[i]    = 16'h0100 + 16'(i);
      ref_mem[i] = 16'h0100 + 16'(i);
    end
  endtask

  // instruction-level model: predicts stores, holds and instruction count
  task automatic run_model(output int n, output int s);
    logic [15:0] r [8];
    int pc, pend, prev, op, rd, rs, imm;
    bit ua, ub, uw, bad, taken;
    for (int i = 0; i < 8; i++) r[i] = 16'h0;
    pc = 0; pend = -1; prev = -1; n = 0; s = 0;
    while (n < 200) begin
      op  = int'(prog[pc][15:12]);
      rd  = int'(prog[pc][11:9]);
      rs  = int'(prog[pc][8:6]);
      imm = int'(prog[pc][5:0]);
      ua  = (op == 2) || (op == 3) || (op == 4) || (op == 5) || (op == 8);
      ub  = (op >= 3) && (op <= 5);
      uw  = (op == 1) || (op == 3) || (op == 4) || (op == 5) || (op == 6);
      bad = ((ua || uw) && rd > 5) || (ub && rs > 5);
      if (bad) begin ua = 0; ub = 0; uw = 0; op = 0; end
      if ((ua && rd == prev) || (ub && rs == prev)) s++;
      n++;
      taken = 0;
      case (op)
        1: r[rd] = ref_mem[imm];
        2: begin ref_mem[imm] = r[rd]; qa.push_back(6'(imm)); qd.push_back(r[rd]); end
        3: r[rd] = r[rd] + r[rs];
        4: r[rd] = r[rd] - r[rs];
        5: r[rd] = r[rd] * r[rs];
        6: r[rd] = 16'(imm);
        7: taken = 1;
        8: taken = (r[rd] == 16'h0);
        default: ;
      endcase
      prev = uw ? rd : -1;
      if (op == 9) break;
      if (pend >= 0) begin pc = pend; pend = -1; end
      else pc = (pc + 1) % 64;
      if (taken) pend = imm;
    end
  endtask

  task automatic run_prog(input string tag);
    int n, s, cyc, bad;
    logic [5:0] a0;
    cur_tag = tag;
    rst_n = 1'b0;
    load_mems_hook();
    run_model(n, s);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 6'd0, "R1 reset fetch address", int'(imem_addr), 0);
    chk(!dmem_en, "R1 no memory request in reset", int'(dmem_en), 0);
    chk(!done, "R1 done low in reset", int'(done), 0);
    rst_n = 1'b1;
    cyc = 0;
    while (cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
    end
    // R10 / R5: done edge = executed instructions + holds + 2
    chk(done && cyc == n + s + 2, "R10 done edge", cyc, n + s + 2);
    a0 = imem_addr;
    repeat (3) @(negedge clk);
    chk(imem_addr == a0, "R9 fetch frozen after done", int'(imem_addr), int'(a0));
    chk(done, "R9 done held", int'(done), 1);
    chk(qa.size() == 0, "R3 missing stores", qa.size(), 0);
    bad = 0;
    for (int i = 0; i < 64; i++) if (dmem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, "final memory mismatches", bad, 0);
    qa.delete();
    qd.delete();
  endtask

  // per-test memory presets, applied after the default fill
  int pk_n;
  int pk_a [8];
  int pk_v [8];
  task automatic load_mems_hook();
    load_mems();
    for (int i = 0; i < pk_n; i++) poke(pk_a[i], pk_v[i]);
  endtask

  // opcodes (R2): 0 NOP 1 LOAD 2 STORE 3 ADD 4 SUB 5 PROD 6 LDI 7 BRA 8 BRZ 9 HALT
  initial begin
    pk_n = 0;

    // R1 R11: registers start at zero
    new_prog();
    for (int i = 0; i < 6; i++) emit(2, i, 0, i);
    emit(9, 0, 0, 0);
    run_prog("R1");

    // R2 R3 R5 R11: multiply sequence, two back-to-back holds
    new_prog();
    emit(1, 0, 0, 23);
    emit(1, 1, 0, 52);
    emit(5, 0, 1, 0);
    emit(2, 0, 0, 23);
    emit(2, 1, 0, 53);
    emit(9, 0, 0, 0);
    pk_n = 2; pk_a[0] = 23; pk_v[0] = 7; pk_a[1] = 52; pk_v[1] = 9;
    run_prog("R2 R3 R5 R11");
    pk_n = 0;

    // R4: arithmetic with wrap-around
    new_prog();
    emit(6, 0, 0, 5);
    emit(6, 1, 0, 3);
    emit(6, 2, 0, 63);
    emit(3, 0, 1, 0);
    emit(4, 1, 2, 0);
    emit(5, 2, 2, 0);
    emit(6, 4, 0, 63);
    emit(5, 4, 2, 0);
    emit(6, 3, 0, 0);
    emit(4, 3, 0, 0);
    emit(2, 0, 0, 30);
    emit(2, 1, 0, 31);
    emit(2, 2, 0, 32);
    emit(2, 3, 0, 33);
    emit(2, 4, 0, 34);
    emit(9, 0, 0, 0);
    run_prog("R4");

    // R10 R5: independent chain, operands two apart need no hold
    new_prog();
    emit(6, 0, 0, 1);
    emit(6, 1, 0, 2);
    emit(6, 2, 0, 3);
    emit(6, 3, 0, 4);
    emit(3, 0, 2, 0);
    emit(3, 1, 3, 0);
    emit(2, 0, 0, 20);
    emit(2, 1, 0, 21);
    emit(9, 0, 0, 0);
    run_prog("R10 R5");

    // R6: delayed BRA, slot runs, skipped block does not
    new_prog();
    emit(6, 0, 0, 1);
    emit(7, 0, 0, 6);
    emit(6, 1, 0, 7);
    emit(6, 2, 0, 9);
    emit(6, 3, 0, 9);
    emit(9, 0, 0, 0);
    emit(2, 1, 0, 10);
    emit(2, 2, 0, 11);
    emit(2, 3, 0, 12);
    emit(2, 0, 0, 13);
    emit(9, 0, 0, 0);
    run_prog("R6");

    // R7: BRZ not taken on non-zero, taken on zero
    new_prog();
    emit(6, 4, 0, 1);
    emit(8, 4, 0, 5);
    emit(6, 0, 0, 2);
    emit(8, 5, 0, 7);
    emit(6, 1, 0, 3);
    emit(6, 2, 0, 4);
    emit(9, 0, 0, 0);
    emit(2, 0, 0, 40);
    emit(2, 1, 0, 41);
    emit(2, 2, 0, 42);
    emit(9, 0, 0, 0);
    run_prog("R7");

    // R8: register codes 6 and 7 make the word a NOP
    new_prog();
    emit(6, 0, 0, 9);
    emit(6, 6, 0, 5);
    emit(2, 7, 0, 20);
    emit(3, 0, 6, 0);
    emit(2, 0, 0, 21);
    emit(1, 6, 0, 22);
    emit(9, 0, 0, 0);
    run_prog("R8");

    // R9: nothing after HALT executes
    new_prog();
    emit(6, 0, 0, 7);
    emit(2, 0, 0, 50);
    emit(9, 0, 0, 0);
    emit(2, 0, 0, 51);
    emit(6, 1, 0, 1);
    emit(2, 1, 0, 52);
    run_prog("R9");

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule